// File: doc/BRIEF.md
# Memory-Resident Loop Step Engine

This block performs one step of an up-counting loop whose state lives in byte-wide memory rather than in registers. A pulse on `start` latches a 24-bit base pointer. The engine then fetches the 32-bit counter stored at that pointer, adds one and writes the result back. It fetches the 32-bit end value stored four bytes higher and reports on `zero_flag` whether the stepped counter has reached that end value.

A sequencer that runs a counted loop issues one step per iteration and branches on `zero_flag`. The counter can start at any value and climbs toward the stored end value, so the loop can cover any range between two values. While a step is in progress the block owns the memory port. `done` marks the single cycle in which the new flag value first appears.

Top module: `loop_step_mem`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), `busy`, `done`, `mem_we` and `zero_flag` are all 0.
- R2: A `start` seen while idle latches `base_addr`, and `busy` is 1 in the following cycle. A `start` or a new `base_addr` presented while a step is running has no effect on that step's addresses, data or result.
- R3: The counter is read as four bytes at base+0..base+3 in consecutive cycles (cycles 1 to 4 after the start edge). The byte at base+0 is the least significant byte, and read data arrives one cycle after its address.
- R4: The counter plus one, modulo 2^32, is written back least significant byte first to base+0..base+3 with `mem_we`=1 in cycles 6 to 9 after the start edge.
- R5: `mem_we` is 1 only while `busy` is 1, and all four counter bytes are written before the first end-value address is presented.
- R6: The end value is read as four little-endian bytes at base+4..base+7 in cycles 10 to 13 after the start edge.
- R7: `zero_flag` becomes 1 if the incremented counter equals the end value and 0 otherwise. The comparison uses the value after the increment, not before it. The flag changes only in the cycle in which `done` is 1, and it holds its value between steps.
- R8: `done` is a one-cycle pulse in cycle 15 after the start edge. `busy` is 1 in cycles 1 to 14 and 0 whenever `done` is 1.
- R9: All memory addresses are computed modulo 2^24, so a base near the top of the address space wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one loop step (accepted only when idle) |
| base_addr | input | 24 | Address of the counter's lowest byte |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| zero_flag | output | 1 | 1 when the stepped counter matched the end value |
| mem_addr | output | 24 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after its address |

## Verification
The bench uses two kinds of step to tell the endianness and carry paths apart. In one, the counter is one below the end value. In the other, the counter is `00FFFFFF`, so the carry must ripple into the top byte. A counter of all ones with an end value of zero checks the modulo wrap. A counter already equal to its end value separates compare-after-increment from compare-before. A run of steps from 1 toward 4 shows the flag staying clear and then setting, and a base of `FFFFFE` checks that addresses wrap. A second `start` with a different base, issued mid-step, must leave the address trace unchanged.

// File: rtl/loop_step_mem.sv
module loop_step_mem #(
  parameter int ADDR_W       = 24,
  parameter int WORD_BYTES   = 4,
  parameter int LIMIT_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              zero_flag,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int IDX_W  = $clog2(WORD_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RDC, S_WR, S_RDL, S_DONE} state_t;

  state_t            st;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] cnt, lim;

  wire last_rd = (idx == IDX_W'(WORD_BYTES));
  wire last_wr = (idx == IDX_W'(WORD_BYTES - 1));
  wire [WORD_W-1:0] inc      = cnt + WORD_W'(1);
  wire [WORD_W-1:0] inc_sh   = inc >> {idx, 3'b000};
  wire [WORD_W-1:0] cnt_shin = (cnt >> 8) | (WORD_W'(mem_rdata) << (WORD_W - 8));
  wire [WORD_W-1:0] lim_shin = (lim >> 8) | (WORD_W'(mem_rdata) << (WORD_W - 8));
  wire [ADDR_W-1:0] ofs      = (st == S_RDL) ? ADDR_W'(LIMIT_OFFSET) : '0;

  assign mem_addr  = base + ofs + ADDR_W'(idx);
  assign mem_we    = (st == S_WR);
  assign mem_wdata = inc_sh[7:0];
  assign busy      = (st == S_RDC) || (st == S_WR) || (st == S_RDL);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base      <= '0;
      idx       <= '0;
      cnt       <= '0;
      lim       <= '0;
      zero_flag <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base <= base_addr;
          idx  <= '0;
          st   <= S_RDC;
        end
        S_RDC: begin
          if (idx != '0) cnt <= cnt_shin;
          if (last_rd) begin
            idx <= '0;
            st  <= S_WR;
          end else idx <= idx + IDX_W'(1);
        end
        S_WR: begin
          if (last_wr) begin
            idx <= '0;
            st  <= S_RDL;
          end else idx <= idx + IDX_W'(1);
        end
        S_RDL: begin
          if (idx != '0) lim <= lim_shin;
          if (last_rd) begin
            zero_flag <= (lim_shin == inc);
            idx       <= '0;
            st        <= S_DONE;
          end else idx <= idx + IDX_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module loop_step_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic zero_flag,
  input logic mem_we
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!busy && !done && !mem_we && !zero_flag));

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  assert_write_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_flag_moves_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done || $stable(zero_flag)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind loop_step_mem loop_step_mem_chk chk_i (.*);

// File: tb/tb_loop_step_mem.sv
module tb_loop_step_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] base_addr = '0;
  logic        busy, done, zero_flag, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #2 clk = ~clk;

  loop_step_mem dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .busy(busy), .done(done), .zero_flag(zero_flag),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [7:0] mem [int];

  function automatic logic [7:0] rdb(input logic [23:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [31:0] peek32(input logic [23:0] a);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[8*i +: 8] = rdb(a + 24'(i));
    return v;
  endfunction

  task automatic poke32(input logic [23:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[int'(a + 24'(i))] = v[8*i +: 8];
  endtask

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= rdb(mem_addr);
  end

  typedef struct packed {
    logic        ca;
    logic [23:0] a;
    logic        we;
    logic [7:0]  wd;
    logic        bz;
    logic        dn;
    logic        z;
  } exp_t;

  exp_t q[$];
  logic zlast = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (q.size() > 0) e = q.pop_front();
      else e = '{ca: 1'b0, a: '0, we: 1'b0, wd: '0, bz: 1'b0, dn: 1'b0, z: zlast};
      zlast = e.z;
      chk(busy == e.bz, "R8 busy", 32'(busy), 32'(e.bz));
      chk(done == e.dn, "R8 done", 32'(done), 32'(e.dn));
      chk(mem_we == e.we, "R5 mem_we", 32'(mem_we), 32'(e.we));
      chk(zero_flag == e.z, "R7 zero_flag", 32'(zero_flag), 32'(e.z));
      if (e.ca) chk(mem_addr == e.a, "R3/R6/R9 mem_addr", 32'(mem_addr), 32'(e.a));
      if (e.we) chk(mem_wdata == e.wd, "R4 mem_wdata", 32'(mem_wdata), 32'(e.wd));
    end
  end

  task automatic step(input logic [23:0] b, input bit intrude, input string tag);
    logic [31:0] c, l, n;
    logic        znew;
    exp_t        e;
    int          guard;
    c = peek32(b);
    l = peek32(b + 24'd4);
    n = c + 32'd1;
    znew = (n == l);
    @(posedge clk); #1;
    e = '{ca: 1'b0, a: '0, we: 1'b0, wd: '0, bz: 1'b0, dn: 1'b0, z: zlast};
    q.push_back(e);
    for (int k = 1; k <= 15; k++) begin
      e = '{ca: 1'b0, a: '0, we: 1'b0, wd: '0, bz: 1'b1, dn: 1'b0, z: zlast};
      if (k <= 4) begin e.ca = 1'b1; e.a = b + 24'(k - 1); end
      if (k >= 6 && k <= 9) begin
        e.ca = 1'b1; e.a = b + 24'(k - 6); e.we = 1'b1; e.wd = n[8*(k-6) +: 8];
      end
      if (k >= 10 && k <= 13) begin e.ca = 1'b1; e.a = b + 24'(k - 6); end
      if (k == 15) begin e.bz = 1'b0; e.dn = 1'b1; e.z = znew; end
      if (k < 15 && e.z != zlast) e.z = zlast;
      q.push_back(e);
    end
    start = 1'b1;
    base_addr = b;
    @(posedge clk); #1;
    start = 1'b0;
    base_addr = 24'h5A5A5A;
    if (intrude) begin
      @(posedge clk); @(posedge clk); #1;
      start = 1'b1;
      base_addr = b + 24'h100;
      @(posedge clk); #1;
      start = 1'b0;
    end
    guard = 0;
    while (q.size() > 0 && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(peek32(b) == n, {tag, " R4 stored counter"}, peek32(b), n);
    chk(zero_flag == znew, {tag, " R7 flag held"}, 32'(zero_flag), 32'(znew));
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk(!busy && !done && !mem_we && !zero_flag, "R1 reset state",
        {28'd0, busy, done, mem_we, zero_flag}, 32'd0);
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;

    poke32(24'h001000, 32'd0); poke32(24'h001004, 32'd1);
    step(24'h001000, 1'b0, "R3 R7 hit");

    poke32(24'h002000, 32'd5); poke32(24'h002004, 32'd100);
    step(24'h002000, 1'b0, "R7 miss");

    poke32(24'h003000, 32'hFFFFFFFF); poke32(24'h003004, 32'd0);
    step(24'h003000, 1'b0, "R4 wrap");

    poke32(24'h004000, 32'h00FFFFFF); poke32(24'h004004, 32'h01000000);
    step(24'h004000, 1'b0, "R3 R6 carry");

    poke32(24'h005000, 32'd7); poke32(24'h005004, 32'd7);
    step(24'h005000, 1'b0, "R7 post-increment");

    poke32(24'hFFFFFE, 32'h12345677); poke32(24'h000002, 32'h12345678);
    step(24'hFFFFFE, 1'b0, "R9 address wrap");

    poke32(24'h006000, 32'hA1B2C3D4); poke32(24'h006004, 32'hA1B2C3D5);
    poke32(24'h006100, 32'h00000010); poke32(24'h006104, 32'h00000011);
    step(24'h006000, 1'b1, "R2 start ignored");
    chk(peek32(24'h006100) == 32'h10, "R2 intruding base untouched", peek32(24'h006100), 32'h10);

    poke32(24'h007000, 32'd1); poke32(24'h007004, 32'd4);
    for (int i = 0; i < 3; i++) step(24'h007000, 1'b0, "R7 loop run");
    chk(peek32(24'h007000) == 32'd4, "R7 loop final count", peek32(24'h007000), 32'd4);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=below 20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule